// File: doc/BRIEF.md
# Auto-Indexing Memory Pointer Unit

This block is a function unit for a processor whose instructions move data between numbered ports. It keeps one address register whose value is the address applied to an attached single-port synchronous memory. The bus side issues a command by naming a port. Some ports are input ports that take a data word. Others are output ports that return a word. The port number alone decides what happens. It can load the pointer, store a word at the pointer, load a word from the pointer, or return the pointer itself. Storing and loading each come in five forms: plain, or with an increment or a decrement of one word applied before or after the access.

Walking a contiguous buffer therefore takes one command per element and needs no separate address arithmetic. The pointer always stays inside the memory and wraps in both directions. Read results come back through a valid/ready pair and are held until the bus takes them. New commands are refused while a read is outstanding.

Top module: `idxptr_unit`

## Requirements
- R1: After reset the pointer is 0, `rd_valid` is low and `cmd_ready` is high.
- R2: Bit 3 of `cmd_port` selects the direction: 0 is an input port that takes `cmd_wdata`, and 1 is an output port that returns `rd_data`. Port 0 loads the pointer with `cmd_wdata` modulo DEPTH.
- R3: Ports 1, 2, 3, 4 and 5 write `cmd_wdata` to memory. They are, in that order, plain, pre-increment, post-increment, pre-decrement and post-decrement.
- R4: Ports 9, 10, 11, 12 and 13 read a memory word into `rd_data`. They use the same five pointer modifiers in the same order.
- R5: A pre-modify port moves the pointer first and accesses the new address. A post-modify port accesses the old address and then moves the pointer. The pointer moves by exactly one word.
- R6: The pointer wraps modulo DEPTH. An increment from DEPTH-1 gives 0 and a decrement from 0 gives DEPTH-1.
- R7: Port 8 returns the pointer, zero-extended, in `rd_data`. It makes no memory access and leaves the pointer unchanged.
- R8: `rd_valid` rises two clock edges after a memory read is accepted and one edge after a pointer read is accepted.
- R9: `rd_valid` and `rd_data` hold until `rd_ready` is seen high. `cmd_ready` is low while a read is pending or its result is unconsumed.
- R10: Ports 6, 7, 14 and 15 are ignored. They cause no memory access, no pointer change and no response.
- R11: `mem_en` is high only in the cycle a storing or loading command is accepted, and `mem_addr` is always below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_port | input | 4 | Port number being accessed |
| cmd_wdata | input | DATA_W | Data for input ports |
| rd_valid | output | 1 | Read result available |
| rd_ready | input | 1 | Bus consumes the read result |
| rd_data | output | DATA_W | Read result |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read strobe |

## Verification
The assertions assume that the attached memory returns read data exactly one cycle after a read strobe. They also assume that `cmd_port`, `cmd_wdata` and `rd_ready` are steady around each clock edge. The bench models the memory with that fixed latency. It drives every input at the falling edge and drops `cmd_valid` right after each acceptance, so no command is offered while a response is held. It walks the pointer across both wrap points using a non-power-of-two depth. It also issues the ignored port numbers while observing the memory strobe.

// File: rtl/idxptr_pkg.sv
package idxptr_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_SETPTR,
      OP_GETPTR,
      OP_STORE,
      OP_LOAD
   } op_kind_e;

   typedef enum logic [2:0] {
      MOD_NONE,
      MOD_PREINC,
      MOD_POSTINC,
      MOD_PREDEC,
      MOD_POSTDEC
   } ptr_mod_e;

   typedef struct packed {
      op_kind_e kind;
      ptr_mod_e modf;
   } port_op_t;

endpackage

// File: rtl/idxptr_decode.sv
module idxptr_decode
   import idxptr_pkg::*;
(
   input  logic [3:0] port_num,
   output port_op_t   op
);

   logic     is_out;
   logic [2:0] fld;
   ptr_mod_e modv;

   assign is_out = port_num[3];
   assign fld    = port_num[2:0];

   always_comb begin
      case (fld)
         3'd2:    modv = MOD_PREINC;
         3'd3:    modv = MOD_POSTINC;
         3'd4:    modv = MOD_PREDEC;
         3'd5:    modv = MOD_POSTDEC;
         default: modv = MOD_NONE;
      endcase
   end

   always_comb begin
      op.modf = MOD_NONE;
      if (fld == 3'd0) begin
         op.kind = is_out ? OP_GETPTR : OP_SETPTR;
      end else if (fld <= 3'd5) begin
         op.kind = is_out ? OP_LOAD : OP_STORE;
         op.modf = modv;
      end else begin
         op.kind = OP_NONE;
      end
   end

endmodule

// File: rtl/idxptr_pointer.sv
module idxptr_pointer
   import idxptr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  port_op_t          op,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] inc_v;
   logic [ADDR_W-1:0] dec_v;
   logic [ADDR_W-1:0] step_v;
   logic [ADDR_W-1:0] load_v;
   logic [ADDR_W-1:0] ptr_d;
   logic              pre_m;
   logic              any_m;

   generate
      if (IS_POW2) begin : g_pow2
         assign inc_v = ptr_q + 1'b1;
         assign dec_v = ptr_q - 1'b1;
      end else begin : g_mod
         assign inc_v = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         assign dec_v = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
      end
   endgenerate

   assign load_v = ADDR_W'(wdata % DATA_W'(DEPTH));
   assign step_v = (op.modf == MOD_PREINC || op.modf == MOD_POSTINC) ? inc_v : dec_v;
   assign pre_m  = (op.modf == MOD_PREINC || op.modf == MOD_PREDEC);
   assign any_m  = (op.modf != MOD_NONE);

   always_comb begin
      ptr_d = ptr_q;
      if (op.kind == OP_SETPTR) begin
         ptr_d = load_v;
      end else if ((op.kind == OP_STORE || op.kind == OP_LOAD) && any_m) begin
         ptr_d = step_v;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (fire) begin
         ptr_q <= ptr_d;
      end
   end

   assign ptr      = ptr_q;
   assign acc_addr = pre_m ? step_v : ptr_q;

endmodule

// File: rtl/idxptr_resp.sv
module idxptr_resp #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_read_go,
   input  logic              ptr_read_go,
   input  logic [DATA_W-1:0] ptr_word,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);

   logic              pend_q;
   logic              vld_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (vld_q && rd_ready) begin
            vld_q <= 1'b0;
         end
         if (pend_q) begin
            pend_q <= 1'b0;
            vld_q  <= 1'b1;
            data_q <= mem_rdata;
         end
         if (mem_read_go) begin
            pend_q <= 1'b1;
         end
         if (ptr_read_go) begin
            vld_q  <= 1'b1;
            data_q <= ptr_word;
         end
      end
   end

   assign rd_valid = vld_q;
   assign rd_data  = data_q;
   assign busy     = pend_q | vld_q;

endmodule

// File: rtl/idxptr_unit.sv
module idxptr_unit
   import idxptr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [3:0]        cmd_port,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("idxptr_unit: DEPTH must be at least 2");
      end
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("idxptr_unit: DATA_W must hold a full pointer");
      end
   endgenerate

   port_op_t          op;
   logic              fire;
   logic              busy;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] acc_addr;

   assign fire      = cmd_valid & ~busy;
   assign cmd_ready = ~busy;

   idxptr_decode u_dec (
      .port_num (cmd_port),
      .op       (op)
   );

   idxptr_pointer #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .op       (op),
      .wdata    (cmd_wdata),
      .ptr      (ptr),
      .acc_addr (acc_addr)
   );

   idxptr_resp #(
      .DATA_W (DATA_W)
   ) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_read_go (fire && op.kind == OP_LOAD),
      .ptr_read_go (fire && op.kind == OP_GETPTR),
      .ptr_word    (DATA_W'(ptr)),
      .mem_rdata   (mem_rdata),
      .rd_ready    (rd_ready),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .busy        (busy)
   );

   assign mem_en    = fire && (op.kind == OP_STORE || op.kind == OP_LOAD);
   assign mem_we    = fire && op.kind == OP_STORE;
   assign mem_addr  = acc_addr;
   assign mem_wdata = cmd_wdata;

endmodule

// File: rtl/idxptr_unit_chk.sv
module idxptr_unit_chk #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [3:0]        cmd_port,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [DATA_W-1:0] rd_data,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);

   logic acc;
   logic ign;
   assign acc = cmd_valid && cmd_ready;
   assign ign = cmd_port[2:1] == 2'b11;

   // R11
   strobe_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> acc);

   // R11
   addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (int'(mem_addr) < DEPTH));

   // R8
   mem_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> !rd_valid ##1 rd_valid);

   // R8
   ptr_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_port == 4'd8) |=> rd_valid);

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   // R9
   no_accept_while_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cmd_ready);

   // R10
   ignored_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ign) |-> !mem_en);

   // R10
   ignored_no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ign) |=> !rd_valid);

   // R7
   ptr_read_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_port == 4'd8) |-> !mem_en);

endmodule

bind idxptr_unit idxptr_unit_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_port  (cmd_port),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready),
   .rd_data   (rd_data),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/idxptr_unit_test.sv
module idxptr_unit_test;

   localparam int DW = 16;
   localparam int DP = 12;
   localparam int AW = $clog2(DP);
   localparam int NV = 18;

   // {port, wdata, expected read data, expected pointer afterwards}
   localparam logic [39:0] VEC [0:NV-1] = '{
      {4'd0,  16'd10,    16'h0000, 4'd10},
      {4'd3,  16'h00A0,  16'h0000, 4'd11},
      {4'd3,  16'h00A1,  16'h0000, 4'd0},
      {4'd1,  16'h00A2,  16'h0000, 4'd0},
      {4'd2,  16'h00A3,  16'h0000, 4'd1},
      {4'd4,  16'h00A4,  16'h0000, 4'd0},
      {4'd4,  16'h00A5,  16'h0000, 4'd11},
      {4'd5,  16'h00A6,  16'h0000, 4'd10},
      {4'd8,  16'h0000,  16'd10,   4'd10},
      {4'd11, 16'h0000,  16'h00A0, 4'd11},
      {4'd9,  16'h0000,  16'h00A6, 4'd11},
      {4'd10, 16'h0000,  16'h00A4, 4'd0},
      {4'd10, 16'h0000,  16'h00A3, 4'd1},
      {4'd13, 16'h0000,  16'h00A3, 4'd0},
      {4'd12, 16'h0000,  16'h00A6, 4'd11},
      {4'd8,  16'h0000,  16'd11,   4'd11},
      {4'd0,  16'd17,    16'h0000, 4'd5},
      {4'd8,  16'h0000,  16'd5,    4'd5}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [3:0]    cmd_port = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          rd_valid;
   logic          rd_ready = 1'b0;
   logic [DW-1:0] rd_data;
   logic          mem_en;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [DW-1:0] bmem [0:DP-1];

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) bmem[mem_addr] <= mem_wdata;
         else        mem_rdata <= bmem[mem_addr];
      end
   end

   idxptr_unit #(.DATA_W(DW), .DEPTH(DP)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_port  (cmd_port),
      .cmd_wdata (cmd_wdata),
      .rd_valid  (rd_valid),
      .rd_ready  (rd_ready),
      .rd_data   (rd_data),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] p, input logic [DW-1:0] d);
      @(negedge clk);
      cmd_port  = p;
      cmd_wdata = d;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic take(output logic [DW-1:0] d, output int lat);
      lat = 1;
      while (!rd_valid && lat < 8) begin
         @(negedge clk);
         lat++;
      end
      d = rd_data;
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
   endtask

   task automatic read_port(input logic [3:0] p, output logic [DW-1:0] d, output int lat);
      issue(p, '0);
      take(d, lat);
   endtask

   initial begin
      logic [DW-1:0] rd;
      logic [DW-1:0] held;
      int lat;
      for (int i = 0; i < DP; i++) bmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 rd_valid", DW'(rd_valid), 0);
      check("R1 cmd_ready", DW'(cmd_ready), 1);
      read_port(4'd8, rd, lat);
      check("R1 pointer", rd, 0);

      // R2 R3 R4 R5 R6: table walk
      for (int i = 0; i < NV; i++) begin
         logic [3:0] p;
         logic [DW-1:0] wd;
         logic [DW-1:0] ed;
         logic [AW-1:0] ep;
         {p, wd, ed, ep} = VEC[i];
         if (p[3]) begin
            read_port(p, rd, lat);
            check("R4 R5 R6 read data", rd, ed);
            check("R8 latency", DW'(lat), (p == 4'd8) ? 1 : 2);
         end else begin
            issue(p, wd);
            check("R3 no reply to store", DW'(rd_valid), 0);
         end
         read_port(4'd8, rd, lat);
         check("R2 R5 R6 pointer", rd, DW'(ep));
      end

      // R10: ignored ports
      for (int k = 0; k < 4; k++) begin
         logic [3:0] ip;
         ip = (k < 2) ? 4'(6 + k) : 4'(12 + k);
         @(negedge clk);
         cmd_port  = ip;
         cmd_wdata = 16'h0003;
         cmd_valid = 1'b1;
         #1;
         check("R10 no mem_en", DW'(mem_en), 0);
         @(negedge clk);
         cmd_valid = 1'b0;
         check("R10 no reply", DW'(rd_valid), 0);
         read_port(4'd8, rd, lat);
         check("R10 pointer kept", rd, 5);
      end

      // R7: pointer read makes no memory access
      @(negedge clk);
      cmd_port  = 4'd8;
      cmd_valid = 1'b1;
      #1;
      check("R7 no mem_en", DW'(mem_en), 0);
      @(negedge clk);
      cmd_valid = 1'b0;
      take(rd, lat);
      check("R7 value", rd, 5);

      // R9: back-pressure on a memory read (pointer 5, mem[5] written first)
      issue(4'd1, 16'h5A5A);
      issue(4'd9, '0);
      @(negedge clk);
      check("R9 valid", DW'(rd_valid), 1);
      held = rd_data;
      check("R9 data", held, 16'h5A5A);
      for (int w = 0; w < 3; w++) begin
         @(negedge clk);
         check("R9 still valid", DW'(rd_valid), 1);
         check("R9 stable", rd_data, held);
         check("R9 cmd_ready low", DW'(cmd_ready), 0);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      check("R9 released", DW'(rd_valid), 0);
      check("R9 ready again", DW'(cmd_ready), 1);

      // R11: strobe only on accepted command
      @(negedge clk);
      check("R11 idle strobe", DW'(mem_en), 0);
      @(negedge clk);
      cmd_port  = 4'd1;
      cmd_wdata = 16'h1234;
      cmd_valid = 1'b1;
      #1;
      check("R11 write strobe", DW'(mem_en & mem_we), 1);
      check("R11 addr", DW'(mem_addr), 5);
      @(negedge clk);
      cmd_valid = 1'b0;

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule